// File: doc/BRIEF.md
# Prescaled 16-bit Up-Counter with Overflow Interrupt

This peripheral keeps a 16-bit count that software sees as two byte-wide registers, a low byte and a high byte, each of which can be read and written over a simple byte bus. A third byte register holds the control settings. The count advances on one of two sources. The internal source is a tick that fires once every four system clocks. The external source is a rising edge on a pin input. Either source passes through a prescaler of 1, 2, 4 or 8 before it reaches the counter.

When the count wraps from its highest value back to zero, a sticky overflow flag is set. The interrupt output is the flag gated by an enable input. A dedicated strobe clears the flag. An external compare unit can zero the count at any time through a special-event reset input.

An external input can be sampled through a two-flop synchronizer, or through a single-flop edge detector for shorter latency. Every path runs in the system clock domain.

Top module: `tmr16_timer`

## Requirements
- R1: After reset the count is 0x0000, the control register reads 0x00, the overflow flag is 0 and the interrupt output is 0.
- R2: Writing address 0 loads count bits 7:0 and writing address 1 loads count bits 15:8. Reading either address returns that byte. A byte write wins over an increment in the same cycle.
- R3: An increment from 0xFFFF gives 0x0000 and sets the overflow flag. The flag stays set until a cycle in which the clear strobe is high and no new wrap occurs. When a wrap and a clear fall in the same cycle, the flag stays set.
- R4: The interrupt output is high exactly when the overflow flag is 1 and the interrupt-enable input is 1.
- R5: Control bit 1 selects the source. With bit 1 at 0, the internal tick fires on every fourth clock after reset, and the count advances by one per tick at prescale 1:1.
- R6: With control bit 0 at 0, the count holds its value, apart from byte writes and the special-event reset.
- R7: Control bits 5:4 set the prescale: 00 advances the count once per source event, 01 once per 2 events, 10 once per 4 and 11 once per 8.
- R8: With bit 1 at 1 and bit 2 at 0, a rising edge on the external input is passed through two synchronizer flops. The count advances at the second clock edge after the edge where the high level is first sampled.
- R9: With bit 1 at 1 and bit 2 at 1, the rising edge is detected against a single flop, and the count advances at the first clock edge where the high level is present. With bit 1 at 0, bit 2 has no effect.
- R10: Control is at address 2. Bits 5:0 are stored and read back, including bit 3, which is stored but otherwise unused. Bits 7:6 always read 0. Address 3 reads 0, and writes to it are ignored.
- R11: A special-event reset sets the count to 0x0000 on the next edge. A byte write in the same cycle takes priority over it.
- R12: A write to any of addresses 0 to 2 restarts the prescaler's event count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Byte write strobe |
| addr | input | 2 | Register address (0 low byte, 1 high byte, 2 control) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register at addr |
| extClkIn | input | 1 | External count input |
| specialReset | input | 1 | Special-event reset from the compare unit |
| ovfClr | input | 1 | Overflow flag clear strobe |
| irqEnable | input | 1 | Interrupt enable |
| countValue | output | 16 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |
| irqOut | output | 1 | Gated overflow interrupt |

## Verification
The internal tick is run at each of the four prescale settings, which separates the ratio decode from the four-clock phase divider. The external input is toggled with several high and low widths in both edge modes. A fixed one- or two-cycle offset in the model's count then shows which detection path is in use, and the fast toggles show whether narrow pulses are lost. Writes, special-event resets and flag clears are placed on the same cycles as increments and wraps, so each priority rule decides a visible count or flag value.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int BYTE_W     = 8;

  localparam logic [REG_ADDR_W-1:0] ADDR_LO  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_HI  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTL = 2'd2;

  // control field positions
  localparam int BIT_RUN    = 0;
  localparam int BIT_SRC    = 1;
  localparam int BIT_NOSYNC = 2;
  localparam int BIT_OSC    = 3;
  localparam int BIT_PS_LO  = 4;
  localparam int BIT_PS_HI  = 5;
  localparam logic [BYTE_W-1:0] CTL_MASK = 8'h3F;

  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic              incr;
    logic [BYTE_W-1:0] data;
  } ctrlStrobes_t;
endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int DIV_PHASES  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  extClkIn,
  output logic [BYTE_W-1:0]     ctrlReg,
  output ctrlStrobes_t          stb
);
  localparam int PH_W = (DIV_PHASES > 1) ? $clog2(DIV_PHASES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_PHASES - 1);

  logic [PH_W-1:0]        phaseQ;
  logic [SYNC_STAGES:0]   syncQ;
  logic                   extPrevQ;
  logic [PS_W-1:0]        psCntQ;
  logic [PS_W-1:0]        psLimit;
  logic                   intTick, edgeSync, edgeRaw, srcEvent, psHit;
  logic                   anyWrite, ctlWrite;

  assign anyWrite = wrEn && (addr != 2'd3);
  assign ctlWrite = wrEn && (addr == ADDR_CTL);

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctlWrite) ctrlReg <= wrData & CTL_MASK;
  end

  // internal tick divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= '0;
    else if (phaseQ == PH_LAST) phaseQ <= '0;
    else phaseQ <= phaseQ + PH_W'(1);
  end
  assign intTick = (phaseQ == PH_LAST);

  // synchronizer chain; top stage is the edge-detect history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      extPrevQ <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-1:0], extClkIn};
      extPrevQ <= extClkIn;
    end
  end
  assign edgeSync = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign edgeRaw  = extClkIn & ~extPrevQ;

  always_comb begin
    if (!ctrlReg[BIT_SRC])        srcEvent = intTick;
    else if (ctrlReg[BIT_NOSYNC]) srcEvent = edgeRaw;
    else                          srcEvent = edgeSync;
  end

  // prescaler
  always_comb begin
    unique case (ctrlReg[BIT_PS_HI:BIT_PS_LO])
      2'b00:   psLimit = PS_W'(0);
      2'b01:   psLimit = PS_W'(1);
      2'b10:   psLimit = PS_W'(3);
      default: psLimit = PS_W'(7);
    endcase
  end

  assign psHit = ctrlReg[BIT_RUN] && srcEvent && (psCntQ == psLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psCntQ <= '0;
    else if (anyWrite) psCntQ <= '0;
    else if (ctrlReg[BIT_RUN] && srcEvent) begin
      if (psCntQ == psLimit) psCntQ <= '0;
      else psCntQ <= psCntQ + PS_W'(1);
    end
  end

  always_comb begin
    stb.wrLo = wrEn && (addr == ADDR_LO);
    stb.wrHi = wrEn && (addr == ADDR_HI);
    stb.incr = psHit;
    stb.data = wrData;
  end
endmodule

// File: rtl/tmr16_datapath.sv
module tmr16_datapath
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     stb,
  input  logic             specialReset,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] countValue,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int HI_W = CNT_W - BYTE_W;

  logic anyCntWrite, wrapNow;

  assign anyCntWrite = stb.wrLo || stb.wrHi;
  assign wrapNow     = stb.incr && !anyCntWrite && !specialReset &&
                       (countValue == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countValue <= '0;
    else if (anyCntWrite) begin
      if (stb.wrLo) countValue[BYTE_W-1:0] <= stb.data;
      if (stb.wrHi) countValue[CNT_W-1:BYTE_W] <= stb.data[HI_W-1:0];
    end
    else if (specialReset) countValue <= '0;
    else if (stb.incr) countValue <= countValue + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (wrapNow) ovfFlag <= 1'b1;
    else if (ovfClr) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer
  import tmr16_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_PHASES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             extClkIn,
  input  logic             specialReset,
  input  logic             ovfClr,
  input  logic             irqEnable,
  output logic [CNT_W-1:0] countValue,
  output logic             ovfFlag,
  output logic             irqOut
);
  ctrlStrobes_t      stb;
  logic [BYTE_W-1:0] ctrlReg;

  tmr16_ctrl #(
    .DIV_PHASES (DIV_PHASES),
    .SYNC_STAGES(SYNC_STAGES),
    .PS_W       (3)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .extClkIn(extClkIn),
    .ctrlReg (ctrlReg),
    .stb     (stb)
  );

  tmr16_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .specialReset(specialReset),
    .ovfClr      (ovfClr),
    .countValue  (countValue),
    .ovfFlag     (ovfFlag)
  );

  always_comb begin
    unique case (addr)
      ADDR_LO:  rdData = countValue[7:0];
      ADDR_HI:  rdData = countValue[15:8];
      ADDR_CTL: rdData = ctrlReg;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = ovfFlag & irqEnable;
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        specialReset,
  input logic        ovfClr,
  input logic        irqEnable,
  input logic [15:0] countValue,
  input logic        ovfFlag,
  input logic        irqOut,
  input logic [7:0]  ctrlReg
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (countValue == 16'h0000 && !ovfFlag && ctrlReg == 8'h00));

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  p_flag_needs_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (countValue == 16'h0000));

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ovfFlag && irqEnable));

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !specialReset) |=>
      (countValue == $past(countValue) || countValue == $past(countValue) + 16'd1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[0] && !wrEn && !specialReset) |=> $stable(countValue));

  p_ctl_top_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[7:6] == 2'b00);

  p_special_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (specialReset && !wrEn) |=> (countValue == 16'h0000));
endmodule

bind tmr16_timer tmr16_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .specialReset(specialReset),
  .ovfClr      (ovfClr),
  .irqEnable   (irqEnable),
  .countValue  (countValue),
  .ovfFlag     (ovfFlag),
  .irqOut      (irqOut),
  .ctrlReg     (ctrlReg)
);

// File: tb/tmr16_timer_tb.sv
`timescale 1ns/1ps
module tmr16_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        extClkIn = 1'b0;
  logic        specialReset = 1'b0;
  logic        ovfClr = 1'b0;
  logic        irqEnable = 1'b0;
  logic [15:0] countValue;
  logic        ovfFlag;
  logic        irqOut;

  always #4 clk = ~clk;  // 125 MHz

  tmr16_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extClkIn(extClkIn), .specialReset(specialReset),
    .ovfClr(ovfClr), .irqEnable(irqEnable), .countValue(countValue),
    .ovfFlag(ovfFlag), .irqOut(irqOut)
  );

  int    testsRun = 0;
  int    testsFailed = 0;
  string curReq = "R1";
  bit    doneFlag = 0;

  // behavioural reference model
  int mCnt, mFlag, mCtl, mPhase, mS1, mS2, mS3, mPrev, mPs;

  task automatic check(input string req, input int act, input int exp, input string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mFlag = 0; mCtl = 0; mPhase = 0;
      mS1 = 0; mS2 = 0; mS3 = 0; mPrev = 0; mPs = 0;
    end else begin
      int tick, src, div, inc, ovf, ext;
      ext = extClkIn;
      tick = (mPhase == 3);
      mPhase = (mPhase + 1) % 4;
      if (((mCtl >> 1) & 1) == 0) src = tick;
      else if (((mCtl >> 2) & 1) == 1) src = ext && !mPrev;
      else src = mS2 && !mS3;
      div = 1 << ((mCtl >> 4) & 3);
      inc = 0;
      if ((mCtl & 1) && src) begin
        if (mPs == div - 1) begin inc = 1; mPs = 0; end
        else mPs = mPs + 1;
      end
      if (wrEn && addr != 3) mPs = 0;
      ovf = 0;
      if (wrEn && addr == 0) mCnt = (mCnt & 'hFF00) | wrData;
      else if (wrEn && addr == 1) mCnt = (mCnt & 'h00FF) | (int'(wrData) << 8);
      else if (specialReset) mCnt = 0;
      else if (inc) begin
        if (mCnt == 'hFFFF) begin mCnt = 0; ovf = 1; end
        else mCnt = mCnt + 1;
      end
      if (ovf) mFlag = 1;
      else if (ovfClr) mFlag = 0;
      if (wrEn && addr == 2) mCtl = wrData & 'h3F;
      mS3 = mS2; mS2 = mS1; mS1 = ext; mPrev = ext;
    end
    #2;
    if (!doneFlag) begin
      check(curReq, countValue, mCnt, "count");
      check(curReq, ovfFlag, mFlag, "overflow flag");
      check("R4", irqOut, (mFlag && irqEnable) ? 1 : 0, "interrupt");
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 2'd0;
  endtask

  task automatic readReg(input string req, input logic [1:0] a, input int exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdData, exp, "read data");
    addr = 2'd0;
  endtask

  task automatic toggleExt(input int hi, input int lo, input int reps);
    for (int i = 0; i < reps; i++) begin
      @(negedge clk); extClkIn = 1'b1;
      idle(hi - 1);
      @(negedge clk); extClkIn = 1'b0;
      idle(lo - 1);
    end
  endtask

  initial begin
    #(8 * 150000);
    testsFailed++;
    $display("FAIL watchdog: run did not finish");
    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset values
    curReq = "R1";
    check("R1", countValue, 0, "count at reset");
    check("R1", ovfFlag, 0, "flag at reset");
    readReg("R1", 2'd2, 8'h00);
    @(negedge clk); rstN = 1'b1;

    // R10 control readback, bit 3 stored, bits 7:6 zero, address 3
    curReq = "R10";
    writeReg(2'd2, 8'hC8);
    readReg("R10", 2'd2, 8'h08);
    writeReg(2'd3, 8'hFF);
    readReg("R10", 2'd3, 8'h00);
    readReg("R10", 2'd2, 8'h08);
    writeReg(2'd2, 8'h00);

    // R2 byte writes and readback
    curReq = "R2";
    writeReg(2'd0, 8'h34);
    writeReg(2'd1, 8'h12);
    readReg("R2", 2'd0, 8'h34);
    readReg("R2", 2'd1, 8'h12);

    // R5 internal tick at 1:1
    curReq = "R5";
    writeReg(2'd2, 8'h01);
    idle(41);
    // R2 write over running count
    curReq = "R2";
    for (int i = 0; i < 6; i++) begin
      writeReg(2'd0, 8'(8'hF0 + i));
      idle(i);
    end
    // R7 prescale ratios, R12 prescaler restart on write
    curReq = "R7";
    writeReg(2'd2, 8'h11); idle(50);
    writeReg(2'd2, 8'h21); idle(70);
    writeReg(2'd2, 8'h31); idle(100);
    curReq = "R12";
    for (int i = 0; i < 5; i++) begin
      writeReg(2'd1, 8'h00);
      idle(7 + 4 * i);
    end
    // R6 hold
    curReq = "R6";
    writeReg(2'd2, 8'h30);
    idle(40);
    // R9 bit 2 ignored for internal source
    curReq = "R9";
    writeReg(2'd2, 8'h05);
    idle(33);

    // R3 wrap, sticky flag, clear; R4 gating
    curReq = "R3";
    writeReg(2'd0, 8'hF8);
    writeReg(2'd1, 8'hFF);
    writeReg(2'd2, 8'h01);
    idle(50);
    curReq = "R4";
    irqEnable = 1'b1; idle(5);
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    idle(3);
    curReq = "R3";
    writeReg(2'd0, 8'hFD);
    writeReg(2'd1, 8'hFF);
    @(negedge clk); ovfClr = 1'b1;
    idle(30);
    @(negedge clk); ovfClr = 1'b0;
    idle(5);
    irqEnable = 1'b0; idle(3);

    // R8 external, synchronized
    curReq = "R8";
    writeReg(2'd2, 8'h03);
    toggleExt(1, 1, 10);
    toggleExt(3, 2, 8);
    toggleExt(2, 5, 6);
    writeReg(2'd2, 8'h13);
    toggleExt(2, 2, 9);
    // R9 external, unsynchronized
    curReq = "R9";
    writeReg(2'd2, 8'h07);
    toggleExt(1, 1, 10);
    toggleExt(4, 3, 7);
    writeReg(2'd2, 8'h27);
    toggleExt(1, 2, 13);

    // R11 special-event reset and priority
    curReq = "R11";
    writeReg(2'd2, 8'h01);
    idle(20);
    @(negedge clk); specialReset = 1'b1;
    @(negedge clk); specialReset = 1'b0;
    idle(10);
    @(negedge clk); specialReset = 1'b1; wrEn = 1'b1; addr = 2'd1; wrData = 8'hA5;
    @(negedge clk); specialReset = 1'b0; wrEn = 1'b0; addr = 2'd0;
    idle(2);
    readReg("R11", 2'd1, 8'hA5);
    idle(10);

    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule